// File: doc/BRIEF.md
# Timer Clock Source Selector and Prescaler

This block decides what advances a general-purpose timer and then divides that event stream by a programmable factor. It works entirely on count-enable pulses in one clock domain. The possible sources are:

- every cycle of the core clock, gated by a counter enable;
- a rising edge on one of four internal trigger lines;
- edges on one of two channel input pins;
- rising edges of an external trigger line that has already been filtered.

All inputs arrive already synchronized and filtered. The output is a single-cycle count-enable pulse for the downstream counter.

Software configures the block through a narrow write port that has two locations: a configuration word and a prescale preload. A written prescale value waits in the preload register. It moves into the active divider only when the update-event input is pulsed, and the same pulse restarts the division. This lets the prescale factor change at a clean boundary chosen by the timer that owns the block.

Top module: `tmr_clksel_psc`

## Requirements
- R1: After reset no output tick is produced while reset is held, the configuration word is all zero (internal-clock source), and both the active and preload prescale values are 0, so the division factor is 1.
- R2: When the external-enable bit is clear and the mode field is not 3'b111, the source pulses on every cycle in which cnt_en is 1 and never in a cycle in which cnt_en is 0.
- R3: With mode 3'b111, external-enable clear and select code 0 to 3, a source pulse occurs in the first cycle in which trig_i[code] is 1 after a cycle in which it was 0.
- R4: With mode 3'b111, external-enable clear and select code 4, every change of level on ch0_i (rising or falling) gives one source pulse.
- R5: With mode 3'b111 and external-enable clear, select code 5 reacts to ch0_i and code 6 reacts to ch1_i. Each reacts to rising edges when its polarity bit is 0 and to falling edges when that bit is 1.
- R6: The rising edges of etr_i are the source whenever the external-enable bit is 1, whatever the mode and select code are. They are also the source when the mode is 3'b111 and the select code is 7. Each rising edge gives exactly one source pulse.
- R7: With an active prescale value P, the tick output goes high for one cycle, one clock after every (P+1)-th source pulse counted from the last update event. With P = 0, every source pulse gives a tick.
- R8: Writing the prescale location changes only the preload register. The division factor in use stays the same until an update event.
- R9: An update event copies the preload value into the active divider and clears the pulse count. A source pulse in the same cycle as the update event is discarded, so no tick follows that cycle.
- R10: A write with wr_en=1 and wr_addr=0 sets the configuration word. Its fields are mode in bits [2:0], select code in [6:4], external-enable in bit 8, channel-0 polarity in bit 12 and channel-1 polarity in bit 13. A write with wr_addr=1 loads wr_data into the prescale preload. Either write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration word, 1 = prescale preload |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Counter enable, gates the internal-clock source |
| upd_evt | input | 1 | Update event: load the prescaler and restart its count |
| trig_i | input | 4 | Internal trigger inputs |
| ch0_i | input | 1 | Channel input 0, already filtered |
| ch1_i | input | 1 | Channel input 1, already filtered |
| etr_i | input | 1 | External trigger, already filtered |
| psc_tick | output | 1 | Single-cycle prescaled count enable |

## Verification
A wrong source selection or a missed edge in the edge registers shows up as a tick in the wrong cycle. At factor 1 this is visible on psc_tick one cycle after the offending input. A corrupted pulse count or active divider value shifts the tick phase. That error becomes visible no later than one full division period after it occurs, and it persists until the next update event. For that reason the bench compares psc_tick in every cycle across all configurations, at several factors, with update events placed at irregular points.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int TRIG_N  = 4;
   localparam int IDX_CH0 = TRIG_N;
   localparam int IDX_CH1 = TRIG_N + 1;
   localparam int IDX_ETR = TRIG_N + 2;
   localparam int IN_W    = TRIG_N + 3;

   localparam logic [2:0] MODE_EXT_EDGE = 3'b111;

   localparam logic [2:0] SEL_CH0_ANY = 3'd4;
   localparam logic [2:0] SEL_CH0_POL = 3'd5;
   localparam logic [2:0] SEL_CH1_POL = 3'd6;
   localparam logic [2:0] SEL_ETR     = 3'd7;

   typedef struct packed {
      logic       pol1;
      logic       pol0;
      logic       ext_en;
      logic [2:0] tsel;
      logic [2:0] mode;
   } tcs_cfg_t;

   function automatic tcs_cfg_t unpack_cfg(input logic [15:0] d);
      tcs_cfg_t c;
      c.mode   = d[2:0];
      c.tsel   = d[6:4];
      c.ext_en = d[8];
      c.pol0   = d[12];
      c.pol1   = d[13];
      return c;
   endfunction

endpackage

// File: rtl/tcs_edge_det.sv
module tcs_edge_det #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   logic [W-1:0] last_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) last_q[i] <= 1'b0;
            else        last_q[i] <= sig_i[i];
         end
         assign rise_o[i] = sig_i[i] & ~last_q[i];
         assign fall_o[i] = ~sig_i[i] & last_q[i];
      end
   endgenerate

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
   import tcs_pkg::*;
(
   input  tcs_cfg_t        cfg,
   input  logic            cnt_en,
   input  logic [IN_W-1:0] rise,
   input  logic [IN_W-1:0] fall,
   output logic            pulse_o
);

   logic sel_edge;

   always_comb begin
      sel_edge = 1'b0;
      case (cfg.tsel)
         SEL_CH0_ANY: sel_edge = rise[IDX_CH0] | fall[IDX_CH0];
         SEL_CH0_POL: sel_edge = cfg.pol0 ? fall[IDX_CH0] : rise[IDX_CH0];
         SEL_CH1_POL: sel_edge = cfg.pol1 ? fall[IDX_CH1] : rise[IDX_CH1];
         SEL_ETR:     sel_edge = rise[IDX_ETR];
         default:     sel_edge = rise[cfg.tsel[1:0]];
      endcase
   end

   always_comb begin
      if (cfg.ext_en)                     pulse_o = rise[IDX_ETR];
      else if (cfg.mode == MODE_EXT_EDGE) pulse_o = sel_edge;
      else                                pulse_o = cnt_en;
   end

endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
   parameter int PSC_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic             pulse_i,
   input  logic [PSC_W-1:0] pre_i,
   output logic [PSC_W-1:0] act_o,
   output logic [PSC_W-1:0] cnt_o,
   output logic             tick_o
);

   logic [PSC_W-1:0] act_q;
   logic [PSC_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = pulse_i & ~upd_i & (cnt_q == act_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
      end else if (upd_i) begin
         act_q <= pre_i;
         cnt_q <= '0;
      end else if (pulse_i) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= wrap;
         end
         assign tick_o = tick_q;
      end else begin : g_comb_out
         assign tick_o = wrap;
      end
   endgenerate

   assign act_o = act_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_clksel_psc.sv
module tmr_clksel_psc
   import tcs_pkg::*;
#(
   parameter int PSC_W   = 16,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cnt_en,
   input  logic              upd_evt,
   input  logic [3:0]        trig_i,
   input  logic              ch0_i,
   input  logic              ch1_i,
   input  logic              etr_i,
   output logic              psc_tick
);

   localparam int CFG_W = 16;

   generate
      if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc
         $error("PSC_W must lie in 1..DATA_W");
      end
      if (DATA_W < CFG_W) begin : g_bad_data
         $error("DATA_W must hold the configuration word");
      end
      if (TRIG_N != 4) begin : g_bad_trig
         $error("select codes assume four trigger inputs");
      end
   endgenerate

   tcs_cfg_t         cfg_q;
   logic [PSC_W-1:0] psc_pre;
   logic [PSC_W-1:0] psc_act;
   logic [PSC_W-1:0] psc_cnt;
   logic [IN_W-1:0]  in_vec;
   logic [IN_W-1:0]  in_rise;
   logic [IN_W-1:0]  in_fall;
   logic             src_pulse;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         psc_pre <= '0;
      end else if (wr_en) begin
         if (!wr_addr) cfg_q   <= unpack_cfg(wr_data[CFG_W-1:0]);
         else          psc_pre <= wr_data[PSC_W-1:0];
      end
   end

   assign in_vec = {etr_i, ch1_i, ch0_i, trig_i};

   tcs_edge_det #(.W(IN_W)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (in_vec),
      .rise_o (in_rise),
      .fall_o (in_fall)
   );

   tcs_src_mux u_mux (
      .cfg     (cfg_q),
      .cnt_en  (cnt_en),
      .rise    (in_rise),
      .fall    (in_fall),
      .pulse_o (src_pulse)
   );

   tcs_prescaler #(.PSC_W(PSC_W), .OUT_REG(OUT_REG)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (upd_evt),
      .pulse_i (src_pulse),
      .pre_i   (psc_pre),
      .act_o   (psc_act),
      .cnt_o   (psc_cnt),
      .tick_o  (psc_tick)
   );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
   parameter int PSC_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             upd_evt,
   input logic             src_pulse,
   input logic             psc_tick,
   input logic [PSC_W-1:0] psc_pre,
   input logic [PSC_W-1:0] psc_act,
   input logic [PSC_W-1:0] psc_cnt
);

   a_r9_upd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> (psc_cnt == '0));

   a_r9_upd_loads: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> (psc_act == $past(psc_pre)));

   a_r8_act_held: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_evt |=> $stable(psc_act));

   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      psc_cnt <= psc_act);

   generate
      if (OUT_REG) begin : g_reg_chk
         a_r7_tick_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            psc_tick |-> $past(src_pulse));
         a_r9_no_tick_after_upd: assert property (@(posedge clk) disable iff (!rst_n)
            upd_evt |=> !psc_tick);
      end
   endgenerate

endmodule

bind tmr_clksel_psc tcs_checker #(.PSC_W(PSC_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_evt   (upd_evt),
   .src_pulse (src_pulse),
   .psc_tick  (psc_tick),
   .psc_pre   (psc_pre),
   .psc_act   (psc_act),
   .psc_cnt   (psc_cnt)
);

// File: tb/sim_tmr_clksel_psc.sv
module sim_tmr_clksel_psc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        cnt_en = 1'b0;
   logic        upd_evt = 1'b0;
   logic [3:0]  trig = '0;
   logic        ch0 = 1'b0, ch1 = 1'b0, etr = 1'b0;
   logic        psc_tick;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // bench mirror of programmed state, from the requirements
   logic [2:0] m_mode = '0, m_tsel = '0;
   logic       m_ext = 1'b0, m_p0 = 1'b0, m_p1 = 1'b0;
   int         m_pre = 0, m_act = 0, m_cnt = 0;
   logic [3:0] p_trig = '0;
   logic       p_ch0 = 1'b0, p_ch1 = 1'b0, p_etr = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #2.5 clk = ~clk;

   tmr_clksel_psc u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_en(cnt_en), .upd_evt(upd_evt),
      .trig_i(trig), .ch0_i(ch0), .ch1_i(ch1), .etr_i(etr),
      .psc_tick(psc_tick)
   );

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: psc_tick=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   // one clock: inputs already driven at this negedge
   task automatic step(input logic we, input logic a, input logic [15:0] d,
                       input logic u, input string tag);
      logic  pulse, exp;
      string req;
      wr_en = we; wr_addr = a; wr_data = d; upd_evt = u;
      if (m_ext) begin
         pulse = etr & ~p_etr; req = "R6";
      end else if (m_mode == 3'b111) begin
         case (m_tsel)
            3'd4: begin pulse = ch0 ^ p_ch0; req = "R4"; end
            3'd5: begin pulse = m_p0 ? (~ch0 & p_ch0) : (ch0 & ~p_ch0); req = "R5"; end
            3'd6: begin pulse = m_p1 ? (~ch1 & p_ch1) : (ch1 & ~p_ch1); req = "R5"; end
            3'd7: begin pulse = etr & ~p_etr; req = "R6"; end
            default: begin
               pulse = trig[m_tsel[1:0]] & ~p_trig[m_tsel[1:0]]; req = "R3";
            end
         endcase
      end else begin
         pulse = cnt_en; req = "R2";
      end
      exp = 1'b0;
      if (u) begin
         m_act = m_pre; m_cnt = 0; req = "R9";
      end else if (pulse) begin
         if (m_cnt == m_act) begin m_cnt = 0; exp = 1'b1; end
         else m_cnt++;
      end
      if (we && !a) begin
         m_mode = d[2:0]; m_tsel = d[6:4]; m_ext = d[8]; m_p0 = d[12]; m_p1 = d[13];
      end
      if (we && a && !u) m_pre = d;
      else if (we && a) m_pre = d;
      if (tag != "") req = tag;
      p_trig = trig; p_ch0 = ch0; p_ch1 = ch1; p_etr = etr;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; upd_evt = 1'b0;
      check(psc_tick, exp, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (3) begin
         @(negedge clk);
         check(psc_tick, 1'b0, "R1");
      end
      rst_n = 1'b1;
      // R2: no pulse with cnt_en low, one per cycle with it high (R1 factor 1)
      cnt_en = 1'b0;
      repeat (3) step(0, 0, 16'h0, 0, "R2");
      cnt_en = 1'b1;
      repeat (4) step(0, 0, 16'h0, 0, "R1");
      // R8: preload write does not alter the active factor
      step(1, 1, 16'd2, 0, "R10");
      repeat (5) step(0, 0, 16'h0, 0, "R8");
      // R9 then R7: factor 3 after update
      step(0, 0, 16'h0, 1, "R9");
      repeat (9) step(0, 0, 16'h0, 0, "R7");
      // sweep over configurations and factors with pseudo-random inputs
      for (int f = 0; f < 3; f++) begin
         for (int c = 0; c < 512; c++) begin
            logic [15:0] cw;
            cw = {2'b00, c[8:7], 3'b000, c[6], 1'b0, c[5:3], 1'b0, c[2:0]};
            step(1, 0, cw, 0, "R10");
            step(1, 1, 16'((f == 2) ? 3 : f), 0, "");
            step(0, 0, 16'h0, 1, "R9");
            for (int k = 0; k < 16; k++) begin
               lfsr = nxt(lfsr);
               trig = lfsr[3:0]; ch0 = lfsr[4]; ch1 = lfsr[5];
               etr = lfsr[6]; cnt_en = lfsr[7] | lfsr[8];
               step(0, 0, 16'h0, (lfsr[15:11] == 5'd0), "");
            end
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule